// File: doc/BRIEF.md
# Beam position latch and readout

This block holds a snapshot of the horizontal and vertical beam counters and hands it to a processor over an 8-bit read port. Reading the trigger register takes the snapshot, but only while the external I/O enable line is high. Each 9-bit counter is then read as two bytes. A private phase flip-flop per counter selects the byte: the low eight bits first, then bit 8 in bit 0, with the upper seven bits taken from the bus-hold latch that sits outside the block.

A status register reports the field, a latch indicator, a bit passed through from the bus-hold latch, the video region and a 4-bit version. Reading the status register puts both phase flip-flops back to the low byte and consumes the latched flag. The data of every counter or status read must be stored into the external bus-hold latch. The block flags these reads on `hold_we` so that the latch can load `rd_data`.

Top module: `beam_latch_readout`

## Requirements
- R1: `rd_sel` decodes as 0 = trigger, 1 = horizontal, 2 = vertical, 3 = status. A trigger read returns `open_bus`. It copies both live counters into the snapshot only when `io_en` is 1, and leaves the snapshot unchanged otherwise.
- R2: A trigger read with `io_en` = 1 sets the latched flag.
- R3: A counter read with its phase clear returns snapshot bits 7:0. With its phase set, it returns `{hold_q[7:1], snapshot[8]}`.
- R4: Each counter read toggles only that counter's phase. The other counter's phase is untouched.
- R5: A status read clears both phases, so the next read of either counter returns its low byte.
- R6: The status byte is `{field_odd, indicator, hold_q[5], region_50hz, version[3:0]}`.
- R7: When `io_en` = 0, the indicator reads 1 and the latched flag is kept. When `io_en` = 1, the indicator is the latched flag, and the read clears it.
- R8: `hold_we` is 1 exactly during reads of the horizontal, vertical or status register.
- R9: After reset the snapshot, the latched flag and both phases are zero.
- R10: With `rd_en` = 0, no state changes and `rd_data` equals `open_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_sel | input | 2 | Register select |
| h_live | input | 9 | Live horizontal counter |
| v_live | input | 9 | Live vertical counter |
| io_en | input | 1 | External I/O enable line |
| field_odd | input | 1 | Current field |
| region_50hz | input | 1 | 0 for 60 Hz timing, 1 for 50 Hz |
| version | input | 4 | Version number |
| open_bus | input | 8 | Current open-bus byte |
| hold_q | input | 8 | Present value of the bus-hold latch |
| rd_data | output | 8 | Read data, valid in the cycle of the strobe |
| hold_we | output | 1 | Load strobe for the bus-hold latch |

## Verification
The vector walk captures one pair of counter values and then changes the live counters. A read that returns the live value instead of the snapshot is therefore exposed. High-byte reads use bus-hold values with bit 0 set, or with only bit 5 set, to show which hold bits are merged. Horizontal and vertical reads are interleaved, with status reads inside a half-read pair, so that phase sharing or a missed clear gives a different byte. The trigger and status reads are repeated with `io_en` low and then high, which separates the forced indicator, the kept flag and the consumed flag. Directed tests then cover reset, idle strobes, the field bit and `hold_we`.

// File: rtl/beam_pkg.sv
package beam_pkg;
  localparam int CNT_W = 9;
  localparam int BUS_W = 8;
  localparam int VER_W = 4;
  localparam int NUM_CNT = 2;

  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_HCNT = 2'd1,
    SEL_VCNT = 2'd2,
    SEL_STAT = 2'd3
  } beam_sel_e;

  // Byte of a counter: low bits, or top bit merged into bus-hold bits
  function automatic logic [BUS_W-1:0] cnt_byte(input logic [CNT_W-1:0] cnt,
                                                input logic hi,
                                                input logic [BUS_W-1:0] hold);
    if (hi) return {hold[BUS_W-1:1], cnt[CNT_W-1]};
    return cnt[BUS_W-1:0];
  endfunction

  function automatic logic [BUS_W-1:0] status_byte(input logic fld,
                                                   input logic ind,
                                                   input logic hold5,
                                                   input logic reg50,
                                                   input logic [VER_W-1:0] ver);
    return {fld, ind, hold5, reg50, ver};
  endfunction
endpackage

// File: rtl/beam_capture.sv
module beam_capture
  import beam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_go,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] h_live,
  input  logic [CNT_W-1:0] v_live,
  output logic [CNT_W-1:0] cap_h,
  output logic [CNT_W-1:0] cap_v,
  output logic             cap_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_h    <= '0;
      cap_v    <= '0;
      cap_flag <= 1'b0;
    end else begin
      if (cap_go) begin
        cap_h <= h_live;
        cap_v <= v_live;
      end
      if (cap_go)        cap_flag <= 1'b1;
      else if (flag_clr) cap_flag <= 1'b0;
    end
  end

  p_capture_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_go |=> cap_flag);
  p_hold_snapshot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_go |=> $stable(cap_h) && $stable(cap_v));
endmodule

// File: rtl/beam_phase.sv
module beam_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic clear,
  output logic phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= 1'b0;
    else if (clear)  phase <= 1'b0;
    else if (toggle) phase <= ~phase;
  end

  p_toggle_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !clear) |=> phase != $past(phase));
  p_clear_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !phase);
endmodule

// File: rtl/beam_latch_readout.sv
module beam_latch_readout
  import beam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  input  logic [CNT_W-1:0] h_live,
  input  logic [CNT_W-1:0] v_live,
  input  logic             io_en,
  input  logic             field_odd,
  input  logic             region_50hz,
  input  logic [VER_W-1:0] version,
  input  logic [BUS_W-1:0] open_bus,
  input  logic [BUS_W-1:0] hold_q,
  output logic [BUS_W-1:0] rd_data,
  output logic             hold_we
);
  beam_sel_e sel;
  assign sel = beam_sel_e'(rd_sel);

  // Named access events
  logic rd_trig, rd_stat, cap_go, flag_clr;
  logic [NUM_CNT-1:0] rd_cnt;
  assign rd_trig  = rd_en && (sel == SEL_TRIG);
  assign rd_stat  = rd_en && (sel == SEL_STAT);
  assign rd_cnt[0] = rd_en && (sel == SEL_HCNT);
  assign rd_cnt[1] = rd_en && (sel == SEL_VCNT);
  assign cap_go   = rd_trig && io_en;
  assign flag_clr = rd_stat && io_en;

  logic [CNT_W-1:0] cap_h, cap_v;
  logic             cap_flag;

  beam_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_go   (cap_go),
    .flag_clr (flag_clr),
    .h_live   (h_live),
    .v_live   (v_live),
    .cap_h    (cap_h),
    .cap_v    (cap_v),
    .cap_flag (cap_flag)
  );

  logic [NUM_CNT-1:0] phase;
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_phase
    beam_phase u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .toggle (rd_cnt[i]),
      .clear  (rd_stat),
      .phase  (phase[i])
    );
  end

  logic indicator;
  assign indicator = io_en ? cap_flag : 1'b1;

  always_comb begin
    rd_data = open_bus;
    if (rd_en) begin
      unique case (sel)
        SEL_TRIG: rd_data = open_bus;
        SEL_HCNT: rd_data = cnt_byte(cap_h, phase[0], hold_q);
        SEL_VCNT: rd_data = cnt_byte(cap_v, phase[1], hold_q);
        SEL_STAT: rd_data = status_byte(field_odd, indicator, hold_q[5],
                                        region_50hz, version);
        default:  rd_data = open_bus;
      endcase
    end
  end

  assign hold_we = rd_en && (sel != SEL_TRIG);

  p_phase_private_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt[0] |=> $stable(phase[1]));
  p_indicator_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !io_en) |-> rd_data[6]);
  p_flag_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !io_en) |=> cap_flag == $past(cap_flag));
  p_flag_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !cap_flag);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(phase) && $stable(cap_flag));
  p_trigger_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_trig |-> !hold_we);
endmodule

// File: tb/beam_latch_readout_tb.sv
module beam_latch_readout_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [8:0] h_live = '0, v_live = '0;
  logic       io_en = 1'b1;
  logic       field_odd = 1'b0;
  logic       region_50hz = 1'b1;
  logic [3:0] version = 4'h3;
  logic [7:0] open_bus = 8'hA5;
  logic [7:0] hold_q = '0;
  logic [7:0] rd_data;
  logic       hold_we;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_latch_readout u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
    .h_live(h_live), .v_live(v_live), .io_en(io_en), .field_odd(field_odd),
    .region_50hz(region_50hz), .version(version), .open_bus(open_bus),
    .hold_q(hold_q), .rd_data(rd_data), .hold_we(hold_we)
  );

  // {sel, io_en, h_live, v_live, hold_q, expected}
  localparam int NV = 20;
  localparam logic [36:0] VEC [NV] = '{
    {2'd3, 1'b1, 9'h000, 9'h000, 8'h00, 8'h13}, // R6 clean status
    {2'd0, 1'b1, 9'h1A5, 9'h0F3, 8'h00, 8'hA5}, // R1 capture
    {2'd1, 1'b1, 9'h000, 9'h000, 8'hFF, 8'hA5}, // R3 h low
    {2'd1, 1'b1, 9'h000, 9'h000, 8'h54, 8'h55}, // R3 h high
    {2'd2, 1'b1, 9'h000, 9'h000, 8'h00, 8'hF3}, // R4 v low
    {2'd2, 1'b1, 9'h000, 9'h000, 8'hAB, 8'hAA}, // R3 v high
    {2'd1, 1'b1, 9'h000, 9'h000, 8'h00, 8'hA5}, // R4 h low again
    {2'd3, 1'b1, 9'h000, 9'h000, 8'h20, 8'h73}, // R7 flag seen
    {2'd3, 1'b1, 9'h000, 9'h000, 8'h00, 8'h13}, // R7 flag consumed
    {2'd1, 1'b1, 9'h000, 9'h000, 8'h00, 8'hA5}, // R5 phase cleared
    {2'd0, 1'b0, 9'h0FF, 9'h1FF, 8'h00, 8'hA5}, // R1 no capture
    {2'd1, 1'b0, 9'h000, 9'h000, 8'h02, 8'h03}, // R1 old h bit8
    {2'd3, 1'b0, 9'h000, 9'h000, 8'h00, 8'h53}, // R7 forced
    {2'd2, 1'b0, 9'h000, 9'h000, 8'h00, 8'hF3}, // R1 old v low
    {2'd0, 1'b1, 9'h0FF, 9'h1FF, 8'h00, 8'hA5}, // R2 capture
    {2'd3, 1'b0, 9'h000, 9'h000, 8'h00, 8'h53}, // R7 forced, kept
    {2'd3, 1'b1, 9'h000, 9'h000, 8'h00, 8'h53}, // R7 kept flag
    {2'd3, 1'b1, 9'h000, 9'h000, 8'h00, 8'h13}, // R7 consumed
    {2'd2, 1'b1, 9'h000, 9'h000, 8'h00, 8'hFF}, // R3 new v low
    {2'd2, 1'b1, 9'h000, 9'h000, 8'h00, 8'h01}  // R3 new v high
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 time unit later, state updates at next posedge
  task automatic do_read(input logic [1:0] s, input logic io, input logic [8:0] h,
                         input logic [8:0] v, input logic [7:0] hq,
                         input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = s; io_en = io; h_live = h; v_live = v; hold_q = hq;
    #1;
    check(rd_data == exp, req, rd_data, exp);
    check(hold_we == (s != 2'd0), "R8", hold_we, s != 2'd0);
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    do_read(2'd1, 1'b1, 9'h1FF, 9'h1FF, 8'h00, 8'h00, "R9 h low");
    do_read(2'd1, 1'b1, 9'h1FF, 9'h1FF, 8'h00, 8'h00, "R9 h high");
    do_read(2'd3, 1'b1, 9'h1FF, 9'h1FF, 8'h00, 8'h13, "R9 flag");
    do_read(2'd2, 1'b1, 9'h1FF, 9'h1FF, 8'h00, 8'h00, "R9 v");

    for (int i = 0; i < NV; i++) begin
      logic [36:0] e;
      e = VEC[i];
      do_read(e[36:35], e[34], e[33:25], e[24:16], e[15:8], e[7:0],
              $sformatf("R1-7 vec%0d", i));
    end
    idle();

    // R10: idle strobes change nothing
    do_read(2'd0, 1'b1, 9'h155, 9'h0AA, 8'h00, 8'hA5, "R2 capture");
    do_read(2'd1, 1'b1, 9'h000, 9'h000, 8'h00, 8'h55, "R3 h low");
    @(negedge clk);
    rd_en = 1'b0; rd_sel = 2'd1; open_bus = 8'h3C;
    #1 check(rd_data == 8'h3C, "R10 idle data", rd_data, 8'h3C);
    check(hold_we == 1'b0, "R10 idle hold_we", hold_we, 0);
    @(negedge clk);
    rd_sel = 2'd3;
    @(negedge clk);
    open_bus = 8'hA5;
    do_read(2'd1, 1'b1, 9'h000, 9'h000, 8'hFE, 8'hFF, "R10 h phase kept");
    // R6: field bit and version pass through
    field_odd = 1'b1; version = 4'hC; region_50hz = 1'b0;
    do_read(2'd3, 1'b1, 9'h000, 9'h000, 8'hDF, 8'hCC, "R6 field/flag");
    do_read(2'd3, 1'b1, 9'h000, 9'h000, 8'h20, 8'hAC, "R6 hold5");
    // R4: vertical phase untouched by horizontal reads
    do_read(2'd1, 1'b1, 9'h000, 9'h000, 8'h00, 8'h55, "R4 h low");
    do_read(2'd2, 1'b1, 9'h000, 9'h000, 8'h00, 8'hAA, "R4 v low");
    do_read(2'd2, 1'b1, 9'h000, 9'h000, 8'h00, 8'h00, "R4 v high");
    idle();

    // R9: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_read(2'd3, 1'b1, 9'h000, 9'h000, 8'h00, 8'h8C, "R9 flag after reset");
    do_read(2'd1, 1'b1, 9'h000, 9'h000, 8'h00, 8'h00, "R9 snapshot after reset");
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule